// File: doc/BRIEF.md
# Guarded Return Address Stack

This block keeps a protected shadow copy of procedure return addresses, next to a working link register. When a call-with-link is accepted, the return address goes into the link register and onto a small on-chip stack in the same cycle. When a procedure return is accepted, the top entry is popped. In check mode the popped entry must equal the link register. If it does, the link register value becomes the return target; if it does not, a control-flow fault is raised and the return is blocked. In direct mode the popped entry itself becomes the return target.

Software cannot store into the stack. A plain store attempt is refused with a fault. Software can adjust the stack by hand with explicit push and pop commands, for example to discard frames on a long jump. It can also write the link register. A profiling port reads any live entry, indexed from the top of the stack, so a call chain can be captured without walking memory. The stack pointer is visible on a read-only output.

At most one stack operation is accepted per cycle. All results and faults are registered and appear one cycle after the request. The depth must be a power of two.

Top module: `ret_guard_stack`

## Requirements
- R1: An accepted call (`callValid`) loads `callAddr` into `linkReg`, pushes it as the new top entry and raises `sp` by one. A software link write (`lrWrEn`, `lrWrData`) loads `linkReg` only in cycles where no call is accepted.
- R2: An accepted return (`retValid`) removes the top entry, lowers `sp` by one and pulses `retTaken` for one cycle.
- R3: With `checkMode`=1, a return whose top entry equals `linkReg` is taken with `retTarget` equal to `linkReg`. On inequality, `faultValid` pulses with `faultCode`=3, `retTaken` stays 0, and `sp` and the stack are unchanged.
- R4: With `checkMode`=0, a return on a non-empty stack is always taken, and `retTarget` equals the popped entry whatever `linkReg` holds.
- R5: `pushCmd` pushes `pushAddr` without touching `linkReg`. `popCmd` removes the top entry, pulses `popDone` and places the removed entry on `retTarget`.
- R6: An ordinary store attempt (`storeReq`) pulses `faultValid` with `faultCode`=4 and leaves `sp` and every stack entry unchanged.
- R7: A call or push command when `sp` equals DEPTH (16) raises `faultCode`=1 (overflow). `sp`, the stack and `linkReg` are then unchanged.
- R8: A return or pop command when `sp` is 0 raises `faultCode`=2 (underflow). No `retTaken` or `popDone` pulse follows.
- R9: The read port returns the entry `rdIdx` places below the top, with 0 meaning the top entry. `rdValid` is 1 only when `rdIdx` < `sp`; otherwise `rdData` is 0.
- R10: If a return and a call are requested in the same cycle, the return is processed and the call is discarded, so nothing is pushed and `linkReg` keeps its value.
- R11: Among the remaining requests the priority is call, then pop command, then push command, then store attempt. Lower-priority requests in the same cycle are discarded and raise no fault.
- R12: After reset, `sp`, `linkReg` and `retTarget` are 0 and no pulse output is active. `faultCode` is 0 whenever `faultValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| checkMode | input | 1 | 1: compare popped entry with link register; 0: use popped entry as target |
| callValid | input | 1 | Call-with-link request |
| callAddr | input | 64 | Return address of the call |
| retValid | input | 1 | Procedure return request |
| pushCmd | input | 1 | Software push command |
| pushAddr | input | 64 | Value for the push command |
| popCmd | input | 1 | Software pop command |
| storeReq | input | 1 | Ordinary store attempt to the stack |
| lrWrEn | input | 1 | Software write of the link register |
| lrWrData | input | 64 | Value for the link register write |
| rdIdx | input | 4 | Profiling read index, 0 = top of stack |
| rdData | output | 64 | Profiling read data |
| rdValid | output | 1 | Read index addresses a live entry |
| linkReg | output | 64 | Current link register |
| sp | output | 5 | Stack pointer (number of live entries) |
| retTaken | output | 1 | Return accepted this cycle |
| popDone | output | 1 | Pop command accepted this cycle |
| retTarget | output | 64 | Return target or popped value |
| faultValid | output | 1 | Fault pulse |
| faultCode | output | 3 | 1 overflow, 2 underflow, 3 mismatch, 4 store |

## Verification
The hardest states to reach are the full stack and a check-mode mismatch. A correct caller never leaves the link register out of step with the stack top. The bench fills all sixteen entries with calls before it issues the overflowing call and push, and it checks that the top entry and the link register are still the sixteenth address. For the mismatch it calls and then overwrites the link register through the software write port, which sets up the divergence. It then confirms that the blocked return leaves the pointer in place.

// File: rtl/rgs_pkg.sv
package rgs_pkg;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_OVERFLOW = 3'd1,
    FLT_UNDERFLW = 3'd2,
    FLT_MISMATCH = 3'd3,
    FLT_STORE    = 3'd4
  } fault_e;

  typedef struct packed {
    logic push;
    logic pushFromCall;
    logic pop;
    logic lrLoadCall;
    logic outLoad;
    logic outFromLr;
  } strobe_t;
endpackage

// File: rtl/rgs_ctrl.sv
module rgs_ctrl
  import rgs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SPW = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           checkMode,
  input  logic           callValid,
  input  logic           retValid,
  input  logic           pushCmd,
  input  logic           popCmd,
  input  logic           storeReq,
  input  logic           topMatch,
  output strobe_t        stb,
  output logic [SPW-1:0] sp,
  output logic           retTaken,
  output logic           popDone,
  output logic           faultValid,
  output logic [2:0]     faultCode
);
  localparam logic [SPW-1:0] FULL = SPW'(DEPTH);

  logic   isFull, isEmpty;
  fault_e nextFault;
  logic   nextRet, nextPop;

  assign isFull  = (sp == FULL);
  assign isEmpty = (sp == '0);

  always_comb begin
    stb       = '0;
    nextFault = FLT_NONE;
    nextRet   = 1'b0;
    nextPop   = 1'b0;
    if (retValid) begin
      if (isEmpty) nextFault = FLT_UNDERFLW;
      else if (checkMode && !topMatch) nextFault = FLT_MISMATCH;
      else begin
        stb.pop       = 1'b1;
        stb.outLoad   = 1'b1;
        stb.outFromLr = checkMode;
        nextRet       = 1'b1;
      end
    end else if (callValid) begin
      if (isFull) nextFault = FLT_OVERFLOW;
      else begin
        stb.push         = 1'b1;
        stb.pushFromCall = 1'b1;
        stb.lrLoadCall   = 1'b1;
      end
    end else if (popCmd) begin
      if (isEmpty) nextFault = FLT_UNDERFLW;
      else begin
        stb.pop     = 1'b1;
        stb.outLoad = 1'b1;
        nextPop     = 1'b1;
      end
    end else if (pushCmd) begin
      if (isFull) nextFault = FLT_OVERFLOW;
      else stb.push = 1'b1;
    end else if (storeReq) begin
      nextFault = FLT_STORE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp         <= '0;
      retTaken   <= 1'b0;
      popDone    <= 1'b0;
      faultValid <= 1'b0;
      faultCode  <= FLT_NONE;
    end else begin
      if (stb.push)     sp <= sp + 1'b1;
      else if (stb.pop) sp <= sp - 1'b1;
      retTaken   <= nextRet;
      popDone    <= nextPop;
      faultValid <= (nextFault != FLT_NONE);
      faultCode  <= nextFault;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    sp <= FULL);

  assert_fault_keeps_sp_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $stable(sp));

  assert_ret_beats_call_R10: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && callValid && !isEmpty && !checkMode) |=> (sp == $past(sp) - 1'b1));

  assert_single_op_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.push, stb.pop}));

  assert_code_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> (faultCode == FLT_NONE));
endmodule

// File: rtl/rgs_datapath.sv
module rgs_datapath
  import rgs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 64,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned SPW  = IW + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb,
  input  logic [SPW-1:0] sp,
  input  logic [AW-1:0]  callAddr,
  input  logic [AW-1:0]  pushAddr,
  input  logic           lrWrEn,
  input  logic [AW-1:0]  lrWrData,
  input  logic [IW-1:0]  rdIdx,
  output logic [AW-1:0]  rdData,
  output logic           rdValid,
  output logic [AW-1:0]  linkReg,
  output logic [AW-1:0]  retTarget,
  output logic           topMatch
);
  logic [AW-1:0] mem [DEPTH];
  logic [IW-1:0] wrIdx, topIdx, rdAddr;
  logic [AW-1:0] pushVal, topEntry;

  assign wrIdx    = sp[IW-1:0];
  assign topIdx   = wrIdx - 1'b1;
  assign rdAddr   = topIdx - rdIdx;
  assign pushVal  = stb.pushFromCall ? callAddr : pushAddr;
  assign topEntry = mem[topIdx];
  assign topMatch = (topEntry == linkReg);
  assign rdValid  = ({1'b0, rdIdx} < sp);
  assign rdData   = rdValid ? mem[rdAddr] : '0;

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrIdx] <= pushVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkReg   <= '0;
      retTarget <= '0;
    end else begin
      if (stb.lrLoadCall) linkReg <= callAddr;
      else if (lrWrEn)    linkReg <= lrWrData;
      if (stb.outLoad) retTarget <= stb.outFromLr ? linkReg : topEntry;
    end
  end

  assert_push_lands_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |=> (topEntry == $past(pushVal)));

  assert_call_link_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.lrLoadCall |=> (linkReg == $past(callAddr)));
endmodule

// File: rtl/ret_guard_stack.sv
module ret_guard_stack
  import rgs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 64,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned SPW  = IW + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           checkMode,
  input  logic           callValid,
  input  logic [AW-1:0]  callAddr,
  input  logic           retValid,
  input  logic           pushCmd,
  input  logic [AW-1:0]  pushAddr,
  input  logic           popCmd,
  input  logic           storeReq,
  input  logic           lrWrEn,
  input  logic [AW-1:0]  lrWrData,
  input  logic [IW-1:0]  rdIdx,
  output logic [AW-1:0]  rdData,
  output logic           rdValid,
  output logic [AW-1:0]  linkReg,
  output logic [SPW-1:0] sp,
  output logic           retTaken,
  output logic           popDone,
  output logic [AW-1:0]  retTarget,
  output logic           faultValid,
  output logic [2:0]     faultCode
);
  strobe_t stb;
  logic    topMatch;

  rgs_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .checkMode(checkMode), .callValid(callValid),
    .retValid(retValid), .pushCmd(pushCmd), .popCmd(popCmd), .storeReq(storeReq),
    .topMatch(topMatch), .stb(stb), .sp(sp), .retTaken(retTaken), .popDone(popDone),
    .faultValid(faultValid), .faultCode(faultCode)
  );

  rgs_datapath #(.DEPTH(DEPTH), .AW(AW)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sp(sp), .callAddr(callAddr),
    .pushAddr(pushAddr), .lrWrEn(lrWrEn), .lrWrData(lrWrData), .rdIdx(rdIdx),
    .rdData(rdData), .rdValid(rdValid), .linkReg(linkReg), .retTarget(retTarget),
    .topMatch(topMatch)
  );
endmodule

// File: tb/test_ret_guard_stack.sv
module test_ret_guard_stack;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        checkMode, callValid, retValid, pushCmd, popCmd, storeReq, lrWrEn;
  logic [63:0] callAddr, pushAddr, lrWrData;
  logic [3:0]  rdIdx;
  logic [63:0] rdData, linkReg, retTarget;
  logic        rdValid, retTaken, popDone, faultValid;
  logic [4:0]  sp;
  logic [2:0]  faultCode;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_guard_stack i_ret_guard_stack (
    .clk(clk), .rstN(rstN), .checkMode(checkMode), .callValid(callValid),
    .callAddr(callAddr), .retValid(retValid), .pushCmd(pushCmd), .pushAddr(pushAddr),
    .popCmd(popCmd), .storeReq(storeReq), .lrWrEn(lrWrEn), .lrWrData(lrWrData),
    .rdIdx(rdIdx), .rdData(rdData), .rdValid(rdValid), .linkReg(linkReg), .sp(sp),
    .retTaken(retTaken), .popDone(popDone), .retTarget(retTarget),
    .faultValid(faultValid), .faultCode(faultCode)
  );

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    checkMode = 1'b1; callValid = 1'b0; retValid = 1'b0; pushCmd = 1'b0;
    popCmd = 1'b0; storeReq = 1'b0; lrWrEn = 1'b0;
    callAddr = '0; pushAddr = '0; lrWrData = '0; rdIdx = '0;
  endtask

  task automatic cycle();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic doReset();
    idle(); rstN = 1'b0;
    cycle(); cycle();
    rstN = 1'b1;
  endtask

  task automatic call(input logic [63:0] a);
    callValid = 1'b1; callAddr = a; cycle();
  endtask

  task automatic push(input logic [63:0] a);
    pushCmd = 1'b1; pushAddr = a; cycle();
  endtask

  task automatic peek(input logic [3:0] i);
    rdIdx = i; #1;
  endtask

  task automatic t_reset();
    doReset();
    check("R12", "sp", 64'(sp), 0);
    check("R12", "linkReg", linkReg, 0);
    check("R12", "retTarget", retTarget, 0);
    check("R12", "pulses", 64'({retTaken, popDone, faultValid}), 0);
    check("R12", "faultCode", 64'(faultCode), 0);
    check("R9", "rdValid empty", 64'(rdValid), 0);
  endtask

  task automatic t_call_check();
    doReset();
    call(64'hA1);
    check("R1", "linkReg", linkReg, 64'hA1);
    check("R1", "sp", 64'(sp), 1);
    peek(0); check("R1", "top", rdData, 64'hA1);
    call(64'hA2);
    check("R1", "linkReg 2", linkReg, 64'hA2);
    retValid = 1'b1; checkMode = 1'b1; cycle();
    check("R2", "retTaken", 64'(retTaken), 1);
    check("R3", "retTarget", retTarget, 64'hA2);
    check("R2", "sp", 64'(sp), 1);
    lrWrEn = 1'b1; lrWrData = 64'hA1; cycle();
    check("R1", "sw link write", linkReg, 64'hA1);
    retValid = 1'b1; cycle();
    check("R3", "retTarget 2", retTarget, 64'hA1);
    check("R2", "sp empty", 64'(sp), 0);
  endtask

  task automatic t_mismatch();
    doReset();
    call(64'hB1);
    lrWrEn = 1'b1; lrWrData = 64'hBAD; cycle();
    retValid = 1'b1; checkMode = 1'b1; cycle();
    check("R3", "faultValid", 64'(faultValid), 1);
    check("R3", "faultCode", 64'(faultCode), 3);
    check("R3", "retTaken", 64'(retTaken), 0);
    check("R3", "sp kept", 64'(sp), 1);
    peek(0); check("R3", "top kept", rdData, 64'hB1);
  endtask

  task automatic t_direct();
    doReset();
    call(64'hC1);
    lrWrEn = 1'b1; lrWrData = 64'h999; cycle();
    retValid = 1'b1; checkMode = 1'b0; cycle();
    check("R4", "retTaken", 64'(retTaken), 1);
    check("R4", "retTarget", retTarget, 64'hC1);
    check("R4", "fault", 64'(faultValid), 0);
    check("R4", "sp", 64'(sp), 0);
  endtask

  task automatic t_cmds();
    doReset();
    push(64'hD1); push(64'hD2);
    check("R5", "sp", 64'(sp), 2);
    check("R5", "link untouched", linkReg, 0);
    peek(0); check("R5", "top", rdData, 64'hD2);
    peek(1); check("R5", "second", rdData, 64'hD1);
    popCmd = 1'b1; cycle();
    check("R5", "popDone", 64'(popDone), 1);
    check("R5", "popped value", retTarget, 64'hD2);
    check("R5", "retTaken", 64'(retTaken), 0);
    check("R5", "sp after pop", 64'(sp), 1);
  endtask

  task automatic t_store();
    doReset();
    push(64'hE1);
    storeReq = 1'b1; cycle();
    check("R6", "faultValid", 64'(faultValid), 1);
    check("R6", "faultCode", 64'(faultCode), 4);
    check("R6", "sp", 64'(sp), 1);
    peek(0); check("R6", "entry", rdData, 64'hE1);
  endtask

  task automatic t_overflow();
    doReset();
    for (int i = 0; i < 16; i++) call(64'h100 + 64'(i));
    check("R7", "sp full", 64'(sp), 16);
    call(64'hDEAD);
    check("R7", "call fault", 64'(faultCode), 1);
    check("R7", "sp", 64'(sp), 16);
    check("R7", "linkReg", linkReg, 64'h10F);
    peek(0); check("R7", "top", rdData, 64'h10F);
    peek(15); check("R9", "bottom", rdData, 64'h100);
    push(64'hBEEF);
    check("R7", "push fault", 64'(faultCode), 1);
    peek(0); check("R7", "top after push", rdData, 64'h10F);
  endtask

  task automatic t_underflow();
    doReset();
    retValid = 1'b1; cycle();
    check("R8", "ret fault", 64'(faultCode), 2);
    check("R8", "retTaken", 64'(retTaken), 0);
    popCmd = 1'b1; cycle();
    check("R8", "pop fault", 64'(faultCode), 2);
    check("R8", "popDone", 64'(popDone), 0);
    check("R8", "sp", 64'(sp), 0);
  endtask

  task automatic t_read();
    doReset();
    push(64'hF1); push(64'hF2); push(64'hF3);
    peek(2); check("R9", "idx2", rdData, 64'hF1);
    check("R9", "idx2 valid", 64'(rdValid), 1);
    peek(3); check("R9", "idx3 valid", 64'(rdValid), 0);
    check("R9", "idx3 data", rdData, 0);
  endtask

  task automatic t_same();
    doReset();
    call(64'h11);
    retValid = 1'b1; callValid = 1'b1; callAddr = 64'h22; checkMode = 1'b0; cycle();
    check("R10", "retTaken", 64'(retTaken), 1);
    check("R10", "retTarget", retTarget, 64'h11);
    check("R10", "sp", 64'(sp), 0);
    check("R10", "linkReg", linkReg, 64'h11);
  endtask

  task automatic t_priority();
    doReset();
    push(64'h31);
    callValid = 1'b1; callAddr = 64'h32; popCmd = 1'b1; pushCmd = 1'b1;
    pushAddr = 64'h33; storeReq = 1'b1; cycle();
    check("R11", "call wins sp", 64'(sp), 2);
    peek(0); check("R11", "call wins top", rdData, 64'h32);
    check("R11", "no fault", 64'(faultValid), 0);
    popCmd = 1'b1; pushCmd = 1'b1; pushAddr = 64'h34; storeReq = 1'b1; cycle();
    check("R11", "pop wins", 64'(popDone), 1);
    check("R11", "pop value", retTarget, 64'h32);
    check("R11", "pop sp", 64'(sp), 1);
    pushCmd = 1'b1; pushAddr = 64'h35; storeReq = 1'b1; cycle();
    check("R11", "push wins sp", 64'(sp), 2);
    check("R11", "push no fault", 64'(faultValid), 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_call_check(); t_mismatch(); t_direct(); t_cmds(); t_store();
        t_overflow(); t_underflow(); t_read(); t_same(); t_priority();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule